// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

The block multiplies two unsigned 16-bit operands into a 32-bit product. It uses one 16-bit adder over sixteen clock cycles, so it trades latency for area. A start pulse captures both operands. The multiplicand goes into a holding register and the multiplier goes into a shift register.

On each step the lowest multiplier bit picks either the multiplicand or zero as the adder's second input. The first input is the upper half of the partial product, taken one place down. The adder's 16-bit sum and its carry-out land in a 17-bit upper register, which holds product bits 31 to 15. The bit that leaves the bottom of the upper register moves into a 15-bit low register, which holds bits 14 to 0.

After the sixteenth step a one-cycle done pulse marks the product as valid. The product then holds until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: After done, `product` equals `mcand * mplier` exactly, both treated as unsigned, for every operand pair including zero, one and 0xFFFF × 0xFFFF.
- R2: If start is accepted at rising edge k, done is 1 only between edges k+16 and k+17, and 0 on every other cycle of that multiply.
- R3: A start that arrives while a multiply is in progress is ignored: that multiply's result and done timing are unchanged.
- R4: When no start is accepted, `product` keeps the value it had after done.
- R5: An accepted start clears `product` to 0 on the cycle that follows it.
- R6: A synchronous reset makes done 0 and `product` 0 on the next cycle. It also aborts any multiply in progress, so that multiply produces no done.
- R7: A start given in the same cycle that done is high is accepted and begins a new multiply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Captures the operands when no multiply is running |
| mcand | input | 16 | Multiplicand |
| mplier | input | 16 | Multiplier |
| product | output | 32 | Product: upper register bits 31..15, low register bits 14..0 |
| done | output | 1 | One-cycle pulse marking a valid product |

## Verification
The checker keeps its own record of whether a multiply is running, based only on start, reset and its own step count. It therefore assumes that start and reset are sampled cleanly at the clock edge, and that the operands only matter on the cycle a start is accepted. The bench changes every input at the falling clock edge. It raises start for exactly one cycle, except for one deliberate mid-run start. That extra start is also a single cycle long, and it carries different operands so that capturing them by mistake would show in the product.

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product,
  output logic           done
);
  localparam int CW = $clog2(W);

  logic          run;
  logic [CW-1:0] step;
  logic [W-1:0]  x_q;
  logic [W-1:0]  y_q;
  logic [W:0]    hi_q;
  logic [W-2:0]  lo_q;

  wire         load = start && !run;
  wire         last = run && (step == CW'(W - 1));
  wire [W:0]   sum  = {1'b0, hi_q[W:1]} + {1'b0, x_q & {W{y_q[0]}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      done <= 1'b0;
      step <= '0;
      x_q  <= '0;
      y_q  <= '0;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      done <= last;
      if (load) begin
        run  <= 1'b1;
        step <= '0;
        x_q  <= mcand;
        y_q  <= mplier;
        hi_q <= '0;
        lo_q <= '0;
      end else if (run) begin
        y_q  <= y_q >> 1;
        hi_q <= sum;
        lo_q <= {hi_q[0], lo_q[W-2:1]};
        step <= step + 1'b1;
        if (last) run <= 1'b0;
      end
    end
  end

  assign product = {hi_q, lo_q};
endmodule

module shift_add_mul_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [2*W-1:0] product,
  input logic           done
);
  localparam int NW = $clog2(W) + 1;

  logic          act;
  logic [NW-1:0] n;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      n   <= '0;
    end else if (act) begin
      if (n == NW'(W)) act <= 1'b0;
      else n <= n + 1'b1;
    end else if (start) begin
      act <= 1'b1;
      n   <= NW'(1);
    end
  end

  // R2
  done_on_time_chk: assert property (@(posedge clk) disable iff (rst)
    (act && n == NW'(W)) |=> done);
  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3
  no_early_done_chk: assert property (@(posedge clk) disable iff (rst)
    (act && n != NW'(W)) |=> !done);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!act && !start) |=> $stable(product));
  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!act && start) |=> (product == '0));
  // R6
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!done && product == '0));
endmodule

bind shift_add_mul shift_add_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .product(product), .done(done)
);

// File: tb/test_shift_add_mul.sv
module test_shift_add_mul;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] mcand = '0;
  logic [15:0] mplier = '0;
  logic [31:0] product;
  logic        done;
  int checks = 0;
  int fails = 0;

  shift_add_mul #(.W(16)) i_shift_add_mul (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .product(product), .done(done)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0; mcand = ~a; mplier = ~b;
  endtask

  task automatic wait_result(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] e;
    int early;
    e = {16'b0, a} * {16'b0, b};
    early = 0;
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      if (done) early++;
    end
    chk(early == 0, "R2 no early done", 32'(early), 32'd0);
    @(negedge clk);
    chk(done == 1'b1, "R2 done at step 16", {31'b0, done}, 32'd1);
    chk(product == e, "R1 product", product, e);
  endtask

  task automatic t_mul(input logic [15:0] a, input logic [15:0] b);
    kick(a, b);
    chk(product == 32'd0, "R5 clear on start", product, 32'd0);
    wait_result(a, b);
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic t_ignore_start();
    logic [31:0] e;
    e = 32'd1234 * 32'd4321;
    kick(16'd1234, 16'd4321);
    repeat (4) @(negedge clk);
    start = 1'b1; mcand = 16'hFFFF; mplier = 16'hFFFF;
    @(negedge clk);
    start = 1'b0;
    for (int i = 6; i < 16; i++) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R3 done timing kept", {31'b0, done}, 32'd1);
    chk(product == e, "R3 result kept", product, e);
    @(negedge clk);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    t_mul(16'hBEEF, 16'h0123);
    v = product;
    repeat (10) @(negedge clk);
    chk(product == v, "R4 product held", product, v);
  endtask

  task automatic t_back_to_back();
    kick(16'h00FF, 16'h0F0F);
    wait_result(16'h00FF, 16'h0F0F);
    start = 1'b1; mcand = 16'h8001; mplier = 16'h7FFE;
    @(negedge clk);
    start = 1'b0;
    chk(product == 32'd0, "R7 restart accepted", product, 32'd0);
    wait_result(16'h8001, 16'h7FFE);
    @(negedge clk);
  endtask

  task automatic t_reset_abort();
    int seen;
    kick(16'h1111, 16'h2222);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(product == 32'd0 && done == 1'b0, "R6 reset state", product, 32'd0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk(seen == 0, "R6 aborted no done", 32'(seen), 32'd0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(product == 32'd0 && done == 1'b0, "R6 reset values", product, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    t_mul(16'd0, 16'd0);
    t_mul(16'd1, 16'hABCD);
    t_mul(16'h5A5A, 16'd1);
    t_mul(16'hFFFF, 16'hFFFF);
    t_mul(16'hFFFF, 16'd0);
    t_mul(16'h8000, 16'h8000);
    t_mul(16'h1357, 16'h9BDF);
    t_ignore_start();
    t_hold();
    t_back_to_back();
    t_reset_abort();
    t_mul(16'd3, 16'd7);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule